// File: doc/BRIEF.md
# Synchronized Clock Output Bank

This block fans one distribution clock out to eight output channels. Each channel either passes the distribution clock straight through (bypass) or sends out a divided copy from its own even-ratio divider. Every channel has its own enable. A global enable, made from an input pin and a register bit, can silence all channels at once.

An active-low synchronization input resets the dividers together. While the input is low, every divided channel is forced low and bypass channels keep running. When the input returns high, every divided channel rises on the same distribution-clock edge, and that edge is also a rising edge of the bypass clock. So all outputs stay phase-coherent afterwards. Channel settings are written into shadow registers. They are copied into the running configuration only at a sync release, so a divide-ratio change can never leave channels out of phase.

The sync path is a controller FSM with two states:
- `ST_HOLD`: divided outputs are held low and the dividers are cleared.
- `ST_RUN`: the dividers count.

The FSM moves from `ST_RUN` to `ST_HOLD` (the transition named *enter_hold*) when the delayed sync sample is low. It moves from `ST_HOLD` to `ST_RUN` (the transition named *release*) when that sample is high. *release* is the edge that loads the shadow settings and starts every divider high.

Top module: `clkdist_bank`

## Requirements
- R1: After reset, all channels are disabled and every bit of `ch_out` is 0. Reset leaves the FSM in `ST_HOLD`, so the first release occurs on its own once `sync_n` is high.
- R2: A write with address 0..7 sets that channel's shadow word. The word format is bit 9 = enable, bit 8 = bypass select (1 = bypass, 0 = divided), and bits 7:0 = half ratio H. A shadow word has no effect on `ch_out` until the next release edge.
- R3: A write to address 8 sets the global enable bit from bit 0, and it takes effect at once; its reset value is 1. When `oe_pin` is 0 or the global bit is 0, all of `ch_out` is 0. Otherwise each channel follows its own enable.
- R4: An enabled bypass channel outputs the distribution clock and is unaffected by `sync_n`.
- R5: A divided channel with half ratio H has period 2·H cycles with 50% duty: H cycles high, then H cycles low. An H of 0 behaves as 1.
- R6: A low `sync_n` sampled at clock edge k forces every divided channel low after edge k+6.
- R7: A high `sync_n` sampled at edge k, following held state, makes every enabled divided channel go high after edge k+6, all on that same edge, with their counters restarted.
- R8: A low pulse of `sync_n` that is released before the outputs have gone low still holds and then releases the outputs, each 6 edges after the matching sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dist_clk | input | 1 | Distribution clock; also the bypass source |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low synchronization request (asynchronous) |
| oe_pin | input | 1 | Global output enable pin, low disables all |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Write address: 0..7 channel, 8 global |
| cfg_wdata | input | 10 | Write data |
| ch_out | output | 8 | Channel outputs |

## Verification
A change on `sync_n` that is set up before edge k shows at the divided outputs just after edge k+6. That delay comes from two synchronizer flops, four delay flops and the divider register. The reference model in the bench keeps the last six `sync_n` samples in a queue and acts on the oldest one. A shadow write made at edge e is used first by a release at a later edge; global-enable changes show right after the write edge. The bench compares all eight outputs 2 ns after each rising edge, when a bypass output must read 1, and 2 ns after each falling edge, when it must read 0. Inputs change only on falling edges.

// File: rtl/clkdist_pkg.sv
package clkdist_pkg;

    parameter int HALF_W = 8;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } sync_st_e;

    typedef struct packed {
        logic              en;
        logic              byp;
        logic [HALF_W-1:0] half;
    } chan_cfg_t;

endpackage

// File: rtl/clkdist_sync.sv
module clkdist_sync #(
    parameter int SYNC_FLOPS = 2,
    parameter int DLY_STAGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    output logic hold_o,
    output logic rel_o
);
    import clkdist_pkg::*;

    localparam int NST = SYNC_FLOPS + DLY_STAGES;

    logic [NST-1:0] sh_q;
    logic           tail;
    sync_st_e       st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[NST-2:0], sync_n};
    end

    assign tail = sh_q[NST-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        hold_o = 1'b0;
        rel_o  = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (!tail) begin
                    st_d   = ST_HOLD;
                    hold_o = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tail) begin
                    st_d  = ST_RUN;
                    rel_o = 1'b1;
                end else begin
                    hold_o = 1'b1;
                end
            end
            default: st_d = ST_HOLD;
        endcase
    end

    // R6
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> (st_q == ST_HOLD));

    // R7
    rel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_o && rel_o));

endmodule

// File: rtl/clkdist_regs.sv
module clkdist_regs #(
    parameter int NCH    = 8,
    parameter int ADDR_W = 4,
    parameter int CFG_W  = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [CFG_W-1:0]          wdata,
    output clkdist_pkg::chan_cfg_t    shd_o [NCH],
    output logic                      glb_o
);
    import clkdist_pkg::*;

    localparam int GLB_ADDR = NCH;

    for (genvar g = 0; g < NCH; g++) begin : g_shd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shd_o[g] <= '{en: 1'b0, byp: 1'b0, half: HALF_W'(1)};
            end else if (we && (addr == ADDR_W'(g))) begin
                shd_o[g] <= chan_cfg_t'(wdata);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   glb_o <= 1'b1;
        else if (we && (addr == ADDR_W'(GLB_ADDR)))   glb_o <= wdata[0];
    end

endmodule

// File: rtl/clkdist_chan.sv
module clkdist_chan (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hold_i,
    input  logic                   rel_i,
    input  clkdist_pkg::chan_cfg_t shd_i,
    input  logic                   glb_ok,
    output logic                   ch_o
);
    import clkdist_pkg::*;

    chan_cfg_t         act_q;
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] last_cnt;
    logic              div_q;

    assign last_cnt = (act_q.half == '0) ? '0 : act_q.half - HALF_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '{en: 1'b0, byp: 1'b0, half: HALF_W'(1)};
        end else if (rel_i) begin
            act_q <= shd_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (hold_i) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (rel_i) begin
            cnt_q <= '0;
            div_q <= 1'b1;
        end else if (cnt_q >= last_cnt) begin
            cnt_q <= '0;
            div_q <= ~div_q;
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end

    assign ch_o = glb_ok & act_q.en & (act_q.byp ? clk : div_q);

    // R6
    div_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !div_q);

    // R7
    div_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |=> (div_q && cnt_q == '0));

endmodule

// File: rtl/clkdist_bank.sv
module clkdist_bank #(
    parameter int NCH        = 8,
    parameter int SYNC_FLOPS = 2,
    parameter int DLY_STAGES = 4,
    parameter int ADDR_W     = $clog2(NCH + 1),
    parameter int CFG_W      = clkdist_pkg::HALF_W + 2
) (
    input  logic              dist_clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              oe_pin,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [NCH-1:0]    ch_out
);
    import clkdist_pkg::*;

    chan_cfg_t shd [NCH];
    logic      glb_bit;
    logic      glb_ok;
    logic      hold;
    logic      rel;

    clkdist_sync #(
        .SYNC_FLOPS (SYNC_FLOPS),
        .DLY_STAGES (DLY_STAGES)
    ) u_sync (
        .clk    (dist_clk),
        .rst_n  (rst_n),
        .sync_n (sync_n),
        .hold_o (hold),
        .rel_o  (rel)
    );

    clkdist_regs #(
        .NCH    (NCH),
        .ADDR_W (ADDR_W),
        .CFG_W  (CFG_W)
    ) u_regs (
        .clk   (dist_clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .shd_o (shd),
        .glb_o (glb_bit)
    );

    assign glb_ok = oe_pin & glb_bit;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        clkdist_chan u_chan (
            .clk    (dist_clk),
            .rst_n  (rst_n),
            .hold_i (hold),
            .rel_i  (rel),
            .shd_i  (shd[g]),
            .glb_ok (glb_ok),
            .ch_o   (ch_out[g])
        );
    end

    // R3
    pin_off_chk: assert property (@(posedge dist_clk) disable iff (!rst_n)
        !oe_pin |-> (ch_out == '0));

endmodule

// File: tb/clkdist_bank_test.sv
module clkdist_bank_test;

    localparam int NCH = 8;

    logic       dist_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b1;
    logic       oe_pin = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [9:0] cfg_wdata = '0;
    logic [7:0] ch_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    string phase_tag = "R1";

    clkdist_bank uut (
        .dist_clk  (dist_clk),
        .rst_n     (rst_n),
        .sync_n    (sync_n),
        .oe_pin    (oe_pin),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ch_out    (ch_out)
    );

    always #5 dist_clk = ~dist_clk;

    // reference model state
    bit     hist[6];
    bit     m_held;
    bit     m_out[NCH];
    int     m_cnt[NCH];
    bit     a_en[NCH], a_byp[NCH];
    int     a_half[NCH];
    bit     s_en[NCH], s_byp[NCH];
    int     s_half[NCH];
    bit     m_glb;

    always @(posedge dist_clk) begin
        if (!rst_n) begin
            foreach (hist[i]) hist[i] = 0;
            m_held = 1; m_glb = 1;
            for (int c = 0; c < NCH; c++) begin
                m_out[c] = 0; m_cnt[c] = 0;
                a_en[c] = 0; a_byp[c] = 0; a_half[c] = 1;
                s_en[c] = 0; s_byp[c] = 0; s_half[c] = 1;
            end
        end else begin
            bit t;
            t = hist[5];
            for (int c = 0; c < NCH; c++) begin
                if (!t) begin
                    m_out[c] = 0; m_cnt[c] = 0;
                end else if (m_held) begin
                    a_en[c] = s_en[c]; a_byp[c] = s_byp[c]; a_half[c] = s_half[c];
                    m_out[c] = 1; m_cnt[c] = 0;
                end else begin
                    int eh;
                    eh = (a_half[c] == 0) ? 1 : a_half[c];
                    if (m_cnt[c] >= eh - 1) begin
                        m_cnt[c] = 0; m_out[c] = !m_out[c];
                    end else m_cnt[c]++;
                end
            end
            m_held = !t;
            for (int i = 5; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = sync_n;
            if (cfg_we) begin
                if (cfg_addr < 8) begin
                    s_en[cfg_addr] = cfg_wdata[9];
                    s_byp[cfg_addr] = cfg_wdata[8];
                    s_half[cfg_addr] = int'(cfg_wdata[7:0]);
                end else if (cfg_addr == 8) m_glb = cfg_wdata[0];
            end
        end
    end

    task automatic compare(input bit hi_phase);
        for (int c = 0; c < NCH; c++) begin
            bit exp;
            string tg;
            exp = m_glb & oe_pin & a_en[c] & (a_byp[c] ? hi_phase : m_out[c]);
            if (!(m_glb & oe_pin)) tg = "R3";
            else if (!a_en[c]) tg = "R1";
            else if (a_byp[c]) tg = "R4";
            else tg = phase_tag;
            checks++;
            if (ch_out[c] !== exp) begin
                errors++;
                $display("FAIL %s ch%0d t=%0t actual=%b expected=%b", tg, c, $time, ch_out[c], exp);
            end
        end
    endtask

    always @(posedge dist_clk) begin
        cycles++;
        if (rst_n && !done) begin
            #2 compare(1'b1);
        end
    end

    always @(negedge dist_clk) begin
        if (rst_n && !done) begin
            #2 compare(1'b0);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [9:0] d);
        @(negedge dist_clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge dist_clk);
        cfg_we = 0;
    endtask

    task automatic sync_pulse(input int low_cycles);
        @(negedge dist_clk);
        sync_n = 0;
        repeat (low_cycles) @(negedge dist_clk);
        sync_n = 1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge dist_clk);
        rst_n = 1;
        repeat (12) @(negedge dist_clk);
        // R1: directed reset-state check
        checks++;
        if (ch_out !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset actual=%h expected=00", ch_out);
        end
        // R2: program shadows; nothing changes before release
        phase_tag = "R2";
        wr(4'd0, 10'b11_0000_0001);   // bypass
        wr(4'd1, 10'b10_0000_0001);   // div 2
        wr(4'd2, 10'b10_0000_0010);   // div 4
        wr(4'd3, 10'b10_0000_0011);   // div 6
        wr(4'd4, 10'b10_0000_0000);   // H=0 acts as 1 (R5)
        wr(4'd5, 10'b00_0000_0010);   // disabled
        wr(4'd6, 10'b10_0000_0101);   // div 10
        wr(4'd7, 10'b11_0000_0011);   // bypass
        repeat (10) @(negedge dist_clk);
        checks++;
        if (ch_out !== 8'h00) begin
            errors++;
            $display("FAIL R2 pre-release actual=%h expected=00", ch_out);
        end
        // R6 / R7: hold and aligned release
        phase_tag = "R6";
        sync_pulse(10);
        phase_tag = "R7";
        repeat (12) @(negedge dist_clk);
        phase_tag = "R5";
        repeat (60) @(negedge dist_clk);
        // R3: global bit and pin
        wr(4'd8, 10'd0);
        repeat (10) @(negedge dist_clk);
        wr(4'd8, 10'd1);
        repeat (5) @(negedge dist_clk);
        oe_pin = 0;
        repeat (10) @(negedge dist_clk);
        oe_pin = 1;
        // R2: new ratios wait for next release
        phase_tag = "R2";
        wr(4'd1, 10'b10_0000_0100);
        wr(4'd2, 10'b10_0000_0001);
        wr(4'd0, 10'b10_0000_0111);
        repeat (30) @(negedge dist_clk);
        // R8: short pulse released before outputs fall
        phase_tag = "R8";
        sync_pulse(2);
        repeat (20) @(negedge dist_clk);
        sync_pulse(1);
        repeat (20) @(negedge dist_clk);
        phase_tag = "R5";
        repeat (80) @(negedge dist_clk);
        finish_run();
    end

    initial begin
        wait (cycles > 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule